// File: doc/BRIEF.md
# Arithmetic Unit with Product and Quotient Registers

This block is the arithmetic and logic unit of a small 16-bit two-operand processor. Each cycle it takes two operands, A and B, and a 4-bit operation code. It returns a combinational result for addition, subtraction, bitwise logic and variable shifts. Multiply and divide send their outcome instead to a pair of internal registers, the upper word and the lower word. These registers are loaded at the next rising clock edge, and their contents are always visible on two output ports.

Three sign flags describe operand A alone, compared with zero as a two's complement number. The surrounding datapath uses them for conditional branches while the unit carries out any operation. Moves from the two registers into the register file are done outside this block, by reading the output ports.

Top module: `aluw_core`

## Requirements
- R1: Operation code 0 (add) drives `result` with (A + B) mod 2^16, in the same cycle and with no carry out.
- R2: Operation code 1 (subtract) drives `result` with (A - B) mod 2^16.
- R3: Operation code 2 gives A AND B, code 3 gives A OR B, and code 4 gives NOT (A OR B), each on `result`.
- R4: Operation code 5 shifts A left. The shift amount is B[3:0] only, B[15:4] are ignored, and zeros fill from the right.
- R5: Operation code 6 shifts A right, logically. The shift amount is B[3:0] only, and zeros fill from the left.
- R6: Operation code 7 (multiply) forms the unsigned 32-bit product of A and B. After the next rising clock edge, `hi_word` holds bits 31:16 of the product and `lo_word` holds bits 15:0.
- R7: Operation code 8 (divide) treats A and B as unsigned. After the next rising clock edge, `lo_word` holds the quotient A / B and `hi_word` holds the remainder A mod B.
- R8: A divide with B equal to zero acts as a divide by one, so `lo_word` becomes A and `hi_word` becomes 0.
- R9: During codes 7 and 8, and during the unused codes 9 to 15, `result` is zero.
- R10: `hi_word` and `lo_word` keep their values across any clock edge where the operation code is neither 7 nor 8.
- R11: `a_pos`, `a_zero` and `a_neg` are 1 when A, read as a signed value, is greater than, equal to, or less than zero. Exactly one of them is high, whatever the operation code.
- R12: While `rst_n` is low, `hi_word` and `lo_word` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the product and quotient registers load on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset for the two registers |
| op | input | 4 | Operation code |
| opnd_a | input | 16 | Operand A; also the value the flags describe |
| opnd_b | input | 16 | Operand B; for shifts only bits 3:0 are used |
| result | output | 16 | Combinational result |
| hi_word | output | 16 | Upper product word or remainder |
| lo_word | output | 16 | Lower product word or quotient |
| a_pos | output | 1 | A is greater than zero, signed |
| a_zero | output | 1 | A equals zero |
| a_neg | output | 1 | A is less than zero, signed |

## Verification
Each operation is tried with several kinds of operand.

- Add and subtract use operands that cross the wrap boundary, so an unmasked carry or borrow shows up.
- Shift amounts carry set bits above bit 3, so using the full B value instead of the masked one gives a different answer.
- A right shift of 0x8000 separates a logical shift from an arithmetic one.
- Multiply uses 0xFFFF times 0xFFFF and 0x0100 times 0x0100, which place bits in both halves.
- Divide uses a dividend with the top bit set, which separates unsigned from signed division, and a zero divisor.
- A flag sweep over 0, 0x7FFF and 0x8000, under different codes, shows that the flags ignore the operation code.

// File: rtl/aluw_pkg.sv
package aluw_pkg;

   typedef enum logic [3:0] {
      OP_ADD = 4'd0,
      OP_SUB = 4'd1,
      OP_AND = 4'd2,
      OP_OR  = 4'd3,
      OP_NOR = 4'd4,
      OP_SLL = 4'd5,
      OP_SRL = 4'd6,
      OP_MUL = 4'd7,
      OP_DIV = 4'd8
   } aluw_op_e;

   localparam int OP_W = 4;

   function automatic logic is_wide_op(logic [OP_W-1:0] code);
      return (code == OP_MUL) || (code == OP_DIV);
   endfunction

endpackage

// File: rtl/aluw_shift.sv
module aluw_shift #(
   parameter int W      = 16,
   parameter int SHW    = $clog2(W),
   parameter bit BARREL = 1'b1
) (
   input  logic [W-1:0]   din,
   input  logic [SHW-1:0] amt,
   input  logic           to_left,
   output logic [W-1:0]   dout
);

   generate
      if (BARREL) begin : g_barrel
         logic [W-1:0] stage [0:SHW];
         assign stage[0] = din;
         for (genvar s = 0; s < SHW; s++) begin : g_stage
            localparam int DIST = 1 << s;
            logic [W-1:0] moved;
            assign moved = to_left ? (stage[s] << DIST) : (stage[s] >> DIST);
            assign stage[s+1] = amt[s] ? moved : stage[s];
         end
         assign dout = stage[SHW];
      end else begin : g_direct
         assign dout = to_left ? (din << amt) : (din >> amt);
      end
   endgenerate

endmodule

// File: rtl/aluw_muldiv.sv
module aluw_muldiv
   import aluw_pkg::*;
#(
   parameter int W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [OP_W-1:0] op,
   input  logic [W-1:0]    a,
   input  logic [W-1:0]    b,
   output logic [W-1:0]    hi,
   output logic [W-1:0]    lo
);

   localparam int PW = 2 * W;

   logic [PW-1:0] product;
   logic [W-1:0]  divisor;
   logic [W-1:0]  quotient;
   logic [W-1:0]  remainder;

   assign product   = {{W{1'b0}}, a} * {{W{1'b0}}, b};
   assign divisor   = (b == '0) ? W'(1) : b;
   assign quotient  = a / divisor;
   assign remainder = a % divisor;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi <= '0;
         lo <= '0;
      end else if (op == OP_MUL) begin
         hi <= product[PW-1:W];
         lo <= product[W-1:0];
      end else if (op == OP_DIV) begin
         hi <= remainder;
         lo <= quotient;
      end
   end

   AST_MUL_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_MUL) |=> ({hi, lo} == ({{W{1'b0}}, $past(a)} * {{W{1'b0}}, $past(b)}))); // R6

   AST_DIV_BY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_DIV && b == '0) |=> (lo == $past(a) && hi == '0)); // R8

   AST_WIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !is_wide_op(op) |=> ($stable(hi) && $stable(lo))); // R10

   AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (hi == '0 && lo == '0)); // R12

endmodule

// File: rtl/aluw_flags.sv
module aluw_flags #(
   parameter int W = 16
) (
   input  logic [W-1:0] val,
   output logic         pos,
   output logic         zero,
   output logic         neg
);

   logic any_set;

   assign any_set = |val;
   assign neg     = val[W-1];
   assign zero    = ~any_set;
   assign pos     = any_set & ~val[W-1];

endmodule

// File: rtl/aluw_core.sv
module aluw_core
   import aluw_pkg::*;
#(
   parameter int W      = 16,
   parameter bit BARREL = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [3:0]      op,
   input  logic [W-1:0]    opnd_a,
   input  logic [W-1:0]    opnd_b,
   output logic [W-1:0]    result,
   output logic [W-1:0]    hi_word,
   output logic [W-1:0]    lo_word,
   output logic            a_pos,
   output logic            a_zero,
   output logic            a_neg
);

   localparam int SHW = $clog2(W);

   generate
      if (W < 2 || (1 << SHW) != W) begin : g_bad_width
         $error("aluw_core: W must be a power of two of at least 2");
      end
   endgenerate

   logic [W-1:0] shifted;
   logic         shift_left;
   logic [W-1:0] sum;
   logic [W-1:0] diff;

   assign sum        = opnd_a + opnd_b;
   assign diff       = opnd_a - opnd_b;
   assign shift_left = (op == OP_SLL);

   aluw_shift #(.W(W), .SHW(SHW), .BARREL(BARREL)) u_shift (
      .din     (opnd_a),
      .amt     (opnd_b[SHW-1:0]),
      .to_left (shift_left),
      .dout    (shifted)
   );

   aluw_muldiv #(.W(W)) u_muldiv (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (op),
      .a     (opnd_a),
      .b     (opnd_b),
      .hi    (hi_word),
      .lo    (lo_word)
   );

   aluw_flags #(.W(W)) u_flags (
      .val  (opnd_a),
      .pos  (a_pos),
      .zero (a_zero),
      .neg  (a_neg)
   );

   always_comb begin
      unique case (op)
         OP_ADD:         result = sum;
         OP_SUB:         result = diff;
         OP_AND:         result = opnd_a & opnd_b;
         OP_OR:          result = opnd_a | opnd_b;
         OP_NOR:         result = ~(opnd_a | opnd_b);
         OP_SLL, OP_SRL: result = shifted;
         default:        result = '0;
      endcase
   end

   AST_WIDE_RESULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      is_wide_op(op) |-> (result == '0)); // R9

   AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot({a_pos, a_zero, a_neg})); // R11

endmodule

// File: tb/aluw_core_tb.sv
module aluw_core_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op = 4'd0;
   logic [15:0] opnd_a = 16'h0;
   logic [15:0] opnd_b = 16'h0;
   logic [15:0] result, hi_word, lo_word;
   logic        a_pos, a_zero, a_neg;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   aluw_core dut_i (
      .clk(clk), .rst_n(rst_n), .op(op), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .result(result), .hi_word(hi_word), .lo_word(lo_word),
      .a_pos(a_pos), .a_zero(a_zero), .a_neg(a_neg)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(logic [3:0] c, logic [15:0] a, logic [15:0] b);
      @(negedge clk);
      op = c; opnd_a = a; opnd_b = b;
      #1;
   endtask

   task automatic past_edge();
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      chk("R12 hi in reset", {16'h0, hi_word}, 32'h0);
      chk("R12 lo in reset", {16'h0, lo_word}, 32'h0);
      drive(4'd7, 16'hFFFF, 16'hFFFF);
      past_edge();
      chk("R12 hi held by reset", {16'h0, hi_word}, 32'h0);
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic t_addsub();
      drive(4'd0, 16'hFFFF, 16'h0002); chk("R1 add wrap", {16'h0, result}, 32'h0001);
      drive(4'd0, 16'h1234, 16'h1111); chk("R1 add", {16'h0, result}, 32'h2345);
      drive(4'd1, 16'h0000, 16'h0001); chk("R2 sub wrap", {16'h0, result}, 32'hFFFF);
      drive(4'd1, 16'h0500, 16'h0100); chk("R2 sub", {16'h0, result}, 32'h0400);
   endtask

   task automatic t_logic();
      drive(4'd2, 16'hA5A5, 16'h0FF0); chk("R3 and", {16'h0, result}, 32'h05A0);
      drive(4'd3, 16'hA5A5, 16'h0FF0); chk("R3 or",  {16'h0, result}, 32'hAFF5);
      drive(4'd4, 16'hA5A5, 16'h0FF0); chk("R3 nor", {16'h0, result}, 32'h500A);
   endtask

   task automatic t_shift();
      drive(4'd5, 16'h0001, 16'h0013); chk("R4 sll masked amount", {16'h0, result}, 32'h0008);
      drive(4'd5, 16'h8421, 16'h000F); chk("R4 sll by 15", {16'h0, result}, 32'h8000);
      drive(4'd6, 16'h8000, 16'h000F); chk("R5 srl logical", {16'h0, result}, 32'h0001);
      drive(4'd6, 16'h8000, 16'h0010); chk("R5 srl amount masked to 0", {16'h0, result}, 32'h8000);
      drive(4'd6, 16'hF0F0, 16'hFF04); chk("R5 srl by 4", {16'h0, result}, 32'h0F0F);
   endtask

   task automatic t_mul();
      drive(4'd7, 16'hFFFF, 16'hFFFF);
      chk("R9 result zero during mul", {16'h0, result}, 32'h0);
      past_edge();
      chk("R6 mul ffff*ffff", {hi_word, lo_word}, 32'hFFFE0001);
      drive(4'd7, 16'h0100, 16'h0100);
      past_edge();
      chk("R6 mul 0100*0100", {hi_word, lo_word}, 32'h00010000);
   endtask

   task automatic t_div();
      drive(4'd8, 16'd100, 16'd7);
      chk("R9 result zero during div", {16'h0, result}, 32'h0);
      past_edge();
      chk("R7 div 100/7 rem:quot", {hi_word, lo_word}, {16'd2, 16'd14});
      drive(4'd8, 16'h8000, 16'd3);
      past_edge();
      chk("R7 div unsigned 8000/3", {hi_word, lo_word}, {16'd2, 16'h2AAA});
      drive(4'd8, 16'h1234, 16'h0000);
      past_edge();
      chk("R8 div by zero", {hi_word, lo_word}, 32'h00001234);
   endtask

   task automatic t_hold();
      drive(4'd7, 16'h0003, 16'h0005);
      past_edge();
      chk("R6 mul 3*5", {hi_word, lo_word}, 32'h0000000F);
      drive(4'd0, 16'hFFFF, 16'hFFFF);
      past_edge();
      chk("R10 hold after add", {hi_word, lo_word}, 32'h0000000F);
      drive(4'd15, 16'h4444, 16'h0002);
      chk("R9 unused code result zero", {16'h0, result}, 32'h0);
      past_edge();
      chk("R10 hold after unused code", {hi_word, lo_word}, 32'h0000000F);
      drive(4'd6, 16'hFFFF, 16'h0001);
      past_edge();
      chk("R10 hold after shift", {hi_word, lo_word}, 32'h0000000F);
   endtask

   task automatic t_flags();
      drive(4'd0, 16'h0000, 16'h0005);
      chk("R11 flags zero", {29'h0, a_pos, a_zero, a_neg}, 32'b010);
      drive(4'd7, 16'h7FFF, 16'h8000);
      chk("R11 flags positive under mul", {29'h0, a_pos, a_zero, a_neg}, 32'b100);
      drive(4'd1, 16'h8000, 16'h0001);
      chk("R11 flags negative under sub", {29'h0, a_pos, a_zero, a_neg}, 32'b001);
      drive(4'd12, 16'hFFFF, 16'h0000);
      chk("R11 flags negative under unused", {29'h0, a_pos, a_zero, a_neg}, 32'b001);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #1;
      t_reset();
      t_addsub();
      t_logic();
      t_shift();
      t_mul();
      t_div();
      t_hold();
      t_flags();
      finish_run();
   end

   initial begin
      #200000;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

endmodule